// File: doc/BRIEF.md
# I2C Interrupt Status Aggregator

This block sits beside an I2C controller core and turns the single-cycle event strobes that the core produces into a 32-bit word of raw interrupt status. Start, stop, general call, address match, slave NACK on the last byte, transmit abort, read request, FIFO overflow and underflow, DMA completion, master-code detect and bus activity each latch into their own bit. The bit stays set until it is cleared. The transmit-empty and receive-full flags are different: they are FIFO levels, so their bits follow the live input instead of latching.

A mask register selects which raw bits reach the masked status word. A single interrupt line is the registered OR of that masked word. A small register bus gives access to both words and to the mask. Every sticky source has its own clear-on-read address, and one more address clears all sticky bits together. Dropping the controller enable clears the activity bit and the general-call bit.

Top module: `i2c_irq_agg`

## Requirements
- R1: Raw status bit positions are fixed as follows:
  - 15: DMA done
  - 14: master-code detect
  - 12: address match
  - 11: general call
  - 10: start, which a repeated start also sets
  - 9: stop
  - 8: activity
  - 7: slave NACK (rx done)
  - 6: tx abort
  - 5: read request
  - 4: tx empty
  - 3: tx over
  - 2: rx full
  - 1: rx over
  - 0: rx under

  Bit 13 and bits 31:16 always read 0. After reset every status bit is 0 and the interrupt line is 0.
- R2: A strobe on a sticky source sets its raw bit at the next clock edge. The mask has no effect on the raw word.
- R3: A sticky bit keeps its value until one of its clear paths acts on it.
- R4: A read of address 16+n clears sticky bit n at the clock edge that ends the read. Reads of the clear addresses for bit 13, bit 4 and bit 2 change nothing.
- R5: A read of address 3 clears every sticky bit at one edge. Bit 4 and bit 2 are not affected.
- R6: While ctl_en is low, bit 8 and bit 11 are cleared at each edge. All other bits keep their values.
- R7: When a strobe and a clear for the same bit fall in the same cycle, the bit is 1 after the edge.
- R8: Bit 4 and bit 2 take the value of lv_tx_empty and lv_rx_full one edge later.
- R9: The mask resets to 0x0000DFFF. A write to address 0 stores the written data ANDed with 0x0000DFFF. Reading address 0 returns the mask.
- R10: mask_stat equals raw_stat AND the mask, and updates in the same cycle as its inputs. Reading address 1 returns mask_stat. Reading address 2, address 3 or any address from 16 to 31 returns raw_stat. Every other address reads 0.
- R11: irq is 1 exactly when mask_stat was nonzero in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_en | input | 1 | Controller enable level |
| ev_start | input | 1 | Start or repeated-start strobe |
| ev_stop | input | 1 | Stop strobe |
| ev_gen_call | input | 1 | Acknowledged general call strobe |
| ev_addr_hit | input | 1 | Address match strobe |
| ev_bus_act | input | 1 | Bus activity strobe |
| ev_slv_nack | input | 1 | Last byte of slave transmit not acknowledged |
| ev_tx_abort | input | 1 | Transmit abort strobe |
| ev_rd_req | input | 1 | Read request strobe |
| ev_tx_over | input | 1 | Transmit FIFO overflow strobe |
| ev_rx_over | input | 1 | Receive FIFO overflow strobe |
| ev_rx_under | input | 1 | Receive FIFO underflow strobe |
| ev_dma_done | input | 1 | DMA completion strobe |
| ev_mcode | input | 1 | Master-code detect strobe |
| lv_tx_empty | input | 1 | Transmit FIFO empty level |
| lv_rx_full | input | 1 | Receive FIFO full level |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the read |
| raw_stat | output | 32 | Raw status word |
| mask_stat | output | 32 | Masked status word |
| irq | output | 1 | Combined interrupt |

## Verification
The results are due at three different times:
- raw_stat changes one edge after a strobe, a level change, a clear read or a drop of ctl_en.
- mask_stat and reg_rdata are combinational and reflect their inputs in the same cycle.
- irq trails mask_stat by one more edge.

The bench drives every input on the falling edge. It reads reg_rdata shortly after driving a read, before the rising edge. It checks raw_stat and mask_stat on the falling edge that follows the rising edge. It checks irq both on that falling edge, where irq must still show the old value, and one cycle later, where it must show the new one.

// File: rtl/i2c_irq_pkg.sv
package i2c_irq_pkg;

  localparam int STAT_W = 32;
  localparam int SRC_N  = 16;
  localparam int AW     = 5;

  localparam int BIT_RX_UNDER = 0;
  localparam int BIT_RX_OVER  = 1;
  localparam int BIT_RX_FULL  = 2;
  localparam int BIT_TX_OVER  = 3;
  localparam int BIT_TX_EMPTY = 4;
  localparam int BIT_RD_REQ   = 5;
  localparam int BIT_TX_ABORT = 6;
  localparam int BIT_SLV_NACK = 7;
  localparam int BIT_ACTIVITY = 8;
  localparam int BIT_STOP     = 9;
  localparam int BIT_START    = 10;
  localparam int BIT_GEN_CALL = 11;
  localparam int BIT_ADDR_HIT = 12;
  localparam int BIT_HOLE     = 13;
  localparam int BIT_MCODE    = 14;
  localparam int BIT_DMA_DONE = 15;

  typedef enum logic [1:0] {
    K_RSVD   = 2'd0,
    K_STICKY = 2'd1,
    K_LEVEL  = 2'd2
  } bit_kind_e;

  // Class of each status position.
  function automatic bit_kind_e kind_of(input int idx);
    if (idx < 0 || idx >= SRC_N || idx == BIT_HOLE) return K_RSVD;
    if (idx == BIT_TX_EMPTY || idx == BIT_RX_FULL) return K_LEVEL;
    return K_STICKY;
  endfunction

  // Positions that the controller enable clears.
  function automatic logic dis_clears(input int idx);
    return (idx == BIT_ACTIVITY) || (idx == BIT_GEN_CALL);
  endfunction

  // Bit vector of all positions of one class.
  function automatic logic [STAT_W-1:0] kind_set(input bit_kind_e k);
    logic [STAT_W-1:0] v;
    v = '0;
    for (int i = 0; i < STAT_W; i++) v[i] = (kind_of(i) == k);
    return v;
  endfunction

  localparam logic [STAT_W-1:0] STICKY_BITS = kind_set(K_STICKY);
  localparam logic [STAT_W-1:0] LEVEL_BITS  = kind_set(K_LEVEL);
  localparam logic [STAT_W-1:0] IMPL_BITS   = STICKY_BITS | LEVEL_BITS;

  function automatic logic [STAT_W-1:0] gate_status(input logic [STAT_W-1:0] raw,
                                                    input logic [STAT_W-1:0] msk);
    return raw & msk & IMPL_BITS;
  endfunction

  function automatic logic fold_any(input logic [STAT_W-1:0] v);
    return |v;
  endfunction

  function automatic logic [STAT_W-1:0] legal_mask(input logic [STAT_W-1:0] wd);
    return wd & IMPL_BITS;
  endfunction

endpackage

// File: rtl/i2c_irq_stat_cell.sv
module i2c_irq_stat_cell
  import i2c_irq_pkg::*;
#(
  parameter bit_kind_e KIND    = K_STICKY,
  parameter bit        DIS_CLR = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);

  logic kill;
  assign kill = clr_i | (DIS_CLR & ~en);

  generate
    if (KIND == K_STICKY) begin : g_sticky
      logic q_r;
      always_ff @(posedge clk) begin
        if (!rst_n) q_r <= 1'b0;
        else        q_r <= set_i | (q_r & ~kill);
      end
      assign q = q_r;

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> q_r); // R7
      AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !q_r); // R4
      AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (q_r && !kill) |=> q_r); // R3
      if (DIS_CLR) begin : g_dis
        AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
          (!en && !set_i) |=> !q_r); // R6
      end
    end else if (KIND == K_LEVEL) begin : g_level
      logic q_r;
      always_ff @(posedge clk) begin
        if (!rst_n) q_r <= 1'b0;
        else        q_r <= set_i;
      end
      assign q = q_r;

      AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (q_r == $past(set_i))); // R8
    end else begin : g_rsvd
      assign q = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/i2c_irq_bank.sv
module i2c_irq_bank
  import i2c_irq_pkg::*;
#(
  parameter int W = STAT_W,
  parameter int N = SRC_N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [N-1:0] src_vec,
  input  logic [W-1:0] clr_vec,
  input  logic         clr_all,
  output logic [W-1:0] raw
);

  localparam int SRC_LAST = N - 1;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      localparam bit_kind_e K = kind_of(i);
      if (K == K_RSVD) begin : g_hole
        assign raw[i] = 1'b0;
      end else begin : g_cell
        logic set_w;
        logic clr_w;
        assign set_w = src_vec[(i > SRC_LAST) ? SRC_LAST : i];
        assign clr_w = clr_vec[i] | clr_all;
        i2c_irq_stat_cell #(
          .KIND    (K),
          .DIS_CLR (dis_clears(i))
        ) u_cell (
          .clk   (clk),
          .rst_n (rst_n),
          .en    (en),
          .set_i (set_w),
          .clr_i (clr_w),
          .q     (raw[i])
        );
      end
    end
  endgenerate

endmodule

// File: rtl/i2c_irq_regif.sv
module i2c_irq_regif
  import i2c_irq_pkg::*;
#(
  parameter int A        = AW,
  parameter int W        = STAT_W,
  parameter int N        = SRC_N,
  parameter int CLR_BASE = 16
) (
  input  logic         reg_wr,
  input  logic         reg_rd,
  input  logic [A-1:0] reg_addr,
  input  logic [W-1:0] reg_wdata,
  input  logic [W-1:0] raw_word,
  input  logic [W-1:0] masked_word,
  input  logic [W-1:0] mask_word,
  output logic         mask_we,
  output logic [W-1:0] mask_wdata,
  output logic         clr_all,
  output logic [W-1:0] clr_vec,
  output logic [W-1:0] reg_rdata
);

  localparam logic [A-1:0] ADDR_MASK   = A'(0);
  localparam logic [A-1:0] ADDR_MSTAT  = A'(1);
  localparam logic [A-1:0] ADDR_RAW    = A'(2);
  localparam logic [A-1:0] ADDR_CLRALL = A'(3);
  localparam int           ADDR_SPAN   = 1 << A;

  logic in_clr_window;

  assign mask_we    = reg_wr && (reg_addr == ADDR_MASK);
  assign mask_wdata = reg_wdata;
  assign clr_all    = reg_rd && (reg_addr == ADDR_CLRALL);

  generate
    for (genvar i = 0; i < W; i++) begin : g_clr
      if (i < N && (CLR_BASE + i) < ADDR_SPAN) begin : g_on
        assign clr_vec[i] = reg_rd && (reg_addr == A'(CLR_BASE + i));
      end else begin : g_off
        assign clr_vec[i] = 1'b0;
      end
    end
  endgenerate

  assign in_clr_window = (int'(reg_addr) >= CLR_BASE) && (int'(reg_addr) < CLR_BASE + N);

  always_comb begin
    reg_rdata = '0;
    if (reg_rd) begin
      if (reg_addr == ADDR_MASK)                                  reg_rdata = mask_word;
      else if (reg_addr == ADDR_MSTAT)                            reg_rdata = masked_word;
      else if (reg_addr == ADDR_RAW || reg_addr == ADDR_CLRALL)   reg_rdata = raw_word;
      else if (in_clr_window)                                     reg_rdata = raw_word;
    end
  end

endmodule

// File: rtl/i2c_irq_out.sv
module i2c_irq_out
  import i2c_irq_pkg::*;
#(
  parameter int W = STAT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mask_we,
  input  logic [W-1:0] mask_wdata,
  input  logic [W-1:0] raw,
  output logic [W-1:0] mask_q,
  output logic [W-1:0] masked,
  output logic         irq
);

  logic [W-1:0] mask_r;
  logic         irq_r;
  logic         any_masked;

  always_ff @(posedge clk) begin
    if (!rst_n)       mask_r <= IMPL_BITS;
    else if (mask_we) mask_r <= legal_mask(mask_wdata);
  end

  assign masked     = gate_status(raw, mask_r);
  assign any_masked = fold_any(masked);

  always_ff @(posedge clk) begin
    if (!rst_n) irq_r <= 1'b0;
    else        irq_r <= any_masked;
  end

  assign mask_q = mask_r;
  assign irq    = irq_r;

  AST_MASK_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_r & ~IMPL_BITS) == '0); // R9
  AST_MASK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    mask_we |=> (mask_r == ($past(mask_wdata) & IMPL_BITS))); // R9
  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_r == $past(|masked))); // R11

endmodule

// File: rtl/i2c_irq_agg.sv
module i2c_irq_agg
  import i2c_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_en,
  input  logic              ev_start,
  input  logic              ev_stop,
  input  logic              ev_gen_call,
  input  logic              ev_addr_hit,
  input  logic              ev_bus_act,
  input  logic              ev_slv_nack,
  input  logic              ev_tx_abort,
  input  logic              ev_rd_req,
  input  logic              ev_tx_over,
  input  logic              ev_rx_over,
  input  logic              ev_rx_under,
  input  logic              ev_dma_done,
  input  logic              ev_mcode,
  input  logic              lv_tx_empty,
  input  logic              lv_rx_full,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [AW-1:0]     reg_addr,
  input  logic [STAT_W-1:0] reg_wdata,
  output logic [STAT_W-1:0] reg_rdata,
  output logic [STAT_W-1:0] raw_stat,
  output logic [STAT_W-1:0] mask_stat,
  output logic              irq
);

  logic [SRC_N-1:0]  src_vec;
  logic [STAT_W-1:0] clr_vec;
  logic              clr_all;
  logic              mask_we;
  logic [STAT_W-1:0] mask_wdata;
  logic [STAT_W-1:0] mask_q;
  logic [STAT_W-1:0] raw_w;
  logic [STAT_W-1:0] masked_w;

  always_comb begin
    src_vec               = '0;
    src_vec[BIT_RX_UNDER] = ev_rx_under;
    src_vec[BIT_RX_OVER]  = ev_rx_over;
    src_vec[BIT_RX_FULL]  = lv_rx_full;
    src_vec[BIT_TX_OVER]  = ev_tx_over;
    src_vec[BIT_TX_EMPTY] = lv_tx_empty;
    src_vec[BIT_RD_REQ]   = ev_rd_req;
    src_vec[BIT_TX_ABORT] = ev_tx_abort;
    src_vec[BIT_SLV_NACK] = ev_slv_nack;
    src_vec[BIT_ACTIVITY] = ev_bus_act;
    src_vec[BIT_STOP]     = ev_stop;
    src_vec[BIT_START]    = ev_start;
    src_vec[BIT_GEN_CALL] = ev_gen_call;
    src_vec[BIT_ADDR_HIT] = ev_addr_hit;
    src_vec[BIT_MCODE]    = ev_mcode;
    src_vec[BIT_DMA_DONE] = ev_dma_done;
  end

  i2c_irq_regif #(
    .A (AW), .W (STAT_W), .N (SRC_N), .CLR_BASE (16)
  ) u_regif (
    .reg_wr      (reg_wr),
    .reg_rd      (reg_rd),
    .reg_addr    (reg_addr),
    .reg_wdata   (reg_wdata),
    .raw_word    (raw_w),
    .masked_word (masked_w),
    .mask_word   (mask_q),
    .mask_we     (mask_we),
    .mask_wdata  (mask_wdata),
    .clr_all     (clr_all),
    .clr_vec     (clr_vec),
    .reg_rdata   (reg_rdata)
  );

  i2c_irq_bank #(
    .W (STAT_W), .N (SRC_N)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (ctl_en),
    .src_vec (src_vec),
    .clr_vec (clr_vec),
    .clr_all (clr_all),
    .raw     (raw_w)
  );

  i2c_irq_out #(
    .W (STAT_W)
  ) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .raw        (raw_w),
    .mask_q     (mask_q),
    .masked     (masked_w),
    .irq        (irq)
  );

  assign raw_stat  = raw_w;
  assign mask_stat = masked_w;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_w & ~IMPL_BITS) == '0); // R1
  AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec)); // R4
  AST_GLOBAL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_all && src_vec == '0) |=> ((raw_w & STICKY_BITS) == '0)); // R5
  AST_START_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> raw_w[BIT_START]); // R2

endmodule

// File: tb/test_i2c_irq_agg.sv
`timescale 1ns/1ps
module test_i2c_irq_agg;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_en;
  logic [15:0] ev;
  logic        lv_tx_empty, lv_rx_full;
  logic        reg_wr, reg_rd;
  logic [4:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata, raw_stat, mask_stat;
  logic        irq;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  i2c_irq_agg i_i2c_irq_agg (
    .clk(clk), .rst_n(rst_n), .ctl_en(ctl_en),
    .ev_start(ev[10]), .ev_stop(ev[9]), .ev_gen_call(ev[11]), .ev_addr_hit(ev[12]),
    .ev_bus_act(ev[8]), .ev_slv_nack(ev[7]), .ev_tx_abort(ev[6]), .ev_rd_req(ev[5]),
    .ev_tx_over(ev[3]), .ev_rx_over(ev[1]), .ev_rx_under(ev[0]),
    .ev_dma_done(ev[15]), .ev_mcode(ev[14]),
    .lv_tx_empty(lv_tx_empty), .lv_rx_full(lv_rx_full),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .raw_stat(raw_stat), .mask_stat(mask_stat), .irq(irq)
  );

  // Expected classes, worked out arithmetically from R1.
  function automatic logic [31:0] impl_bits();
    return 32'h0000_FFFF & ~(32'd1 << 13);
  endfunction
  function automatic logic [31:0] level_bits();
    return (32'd1 << 4) | (32'd1 << 2);
  endfunction
  function automatic logic [31:0] sticky_bits();
    return impl_bits() & ~level_bits();
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic pulse(input logic [15:0] v);
    ev = v;
    tick();
    ev = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    tick();
    reg_rd = 1'b0; reg_addr = '0;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] all_raw;
    logic [31:0] m;
    logic        prev_irq;
    rst_n = 1'b0; ctl_en = 1'b1; ev = '0; lv_tx_empty = 1'b0; lv_rx_full = 1'b0;
    reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 reset raw", raw_stat, 32'h0);
    chk("R1 reset irq", {31'h0, irq}, 32'h0);
    rd(5'd0, d);
    chk("R9 reset mask", d, impl_bits());

    // R2 R3 R4 R11: sweep every sticky source
    for (int n = 0; n < 16; n++) begin
      if (sticky_bits()[n]) begin
        pulse(16'(32'd1 << n));
        chk("R2 set", raw_stat, 32'd1 << n);
        chk("R11 irq lag", {31'h0, irq}, 32'h0);
        tick();
        chk("R11 irq up", {31'h0, irq}, 32'h1);
        tick(); tick();
        chk("R3 hold", raw_stat, 32'd1 << n);
        rd(5'(16 + n), d);
        chk("R10 clear port reads raw", d, 32'd1 << n);
        chk("R4 cleared", raw_stat, 32'h0);
        chk("R11 irq still up", {31'h0, irq}, 32'h1);
        tick();
        chk("R11 irq down", {31'h0, irq}, 32'h0);
      end
    end

    // R2 repeated start is just another start
    pulse(16'h0400); pulse(16'h0400);
    chk("R2 restart", raw_stat, 32'h0000_0400);
    rd(5'd3, d);

    // R8 level tracking
    lv_rx_full = 1'b1;
    #1 chk("R8 not yet", raw_stat & 32'h4, 32'h0);
    tick();
    chk("R8 rx full", raw_stat, 32'h4);
    lv_tx_empty = 1'b1;
    tick();
    chk("R8 tx empty", raw_stat, 32'h14);

    // R4 R5 clear addresses with no effect, then global clear
    pulse(16'(sticky_bits()));
    all_raw = sticky_bits() | level_bits();
    chk("R2 all set", raw_stat, all_raw);
    rd(5'd29, d); rd(5'd20, d); rd(5'd18, d);
    chk("R4 ignored clears", raw_stat, all_raw);
    rd(5'd3, d);
    chk("R10 global reads raw", d, all_raw);
    chk("R5 global clear", raw_stat, level_bits());
    lv_tx_empty = 1'b0; lv_rx_full = 1'b0;
    tick();
    chk("R8 levels drop", raw_stat, 32'h0);

    // R7 set wins over a single clear and over the global clear
    ev = 16'h0400; reg_rd = 1'b1; reg_addr = 5'd26;
    tick();
    ev = '0; reg_rd = 1'b0; reg_addr = '0;
    chk("R7 set beats clear", raw_stat, 32'h0400);
    pulse(16'(sticky_bits()));
    ev = 16'h0040; reg_rd = 1'b1; reg_addr = 5'd3;
    tick();
    ev = '0; reg_rd = 1'b0; reg_addr = '0;
    chk("R7 set beats global", raw_stat, 32'h0040);

    // R6 disable clears activity and general call only
    pulse(16'(sticky_bits()));
    ctl_en = 1'b0;
    tick();
    chk("R6 disable", raw_stat, sticky_bits() & ~((32'd1 << 8) | (32'd1 << 11)));
    ctl_en = 1'b1;
    tick();
    chk("R6 others kept", raw_stat, sticky_bits() & ~32'h0900);

    // R9 R10 R11: mask sweep with everything pending
    pulse(16'(sticky_bits()));
    lv_tx_empty = 1'b1; lv_rx_full = 1'b1;
    tick(); tick();
    all_raw = impl_bits();
    chk("R2 mask ignored on raw", raw_stat, all_raw);
    wr(5'd0, 32'hFFFF_FFFF);
    rd(5'd0, d);
    chk("R9 reserved mask bits", d, impl_bits());
    for (int n = 0; n < 32; n++) begin
      prev_irq = irq;
      m = 32'd1 << n;
      wr(5'd0, m);
      chk("R11 irq old value", {31'h0, irq}, {31'h0, prev_irq});
      chk("R10 masked port", mask_stat, all_raw & m);
      rd(5'd1, d);
      chk("R10 masked read", d, all_raw & m);
      chk("R11 irq follows mask", {31'h0, irq}, {31'h0, (all_raw & m) != 0});
      rd(5'd2, d);
      chk("R1 raw read", d, all_raw);
    end
    wr(5'd0, 32'h0000_2000);
    rd(5'd0, d);
    chk("R9 hole write", d, 32'h0);
    rd(5'd9, d);
    chk("R10 unmapped read", d, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule